// File: doc/BRIEF.md
# Terminal Status and Interrupt Sequencer

This block sits beside the message engine of a MIL-STD-1553B remote terminal. It keeps the 16-bit status word that the terminal returns, and it services the interrupt conditions raised while a message is handled. Two status flags come from events seen during the message: message error and broadcast received. Every other field, including the terminal address, is copied from a configuration register that the host writes.

High-priority conditions are message error and illegal command. Each one sets a pending bit. The high-priority interrupt output is the OR of the pending bits that are enabled. A message error also places the terminal in a hold state. Hold is released only when the host writes a one to the matching bit of the write-one-to-clear acknowledge register.

A standard interrupt request is logged to memory through the DMA master port. One burst writes the interrupt status word, then writes the descriptor block pointer, then reads a tail pointer into an internal register. After the burst the block drives a one-cycle low pulse and raises a level interrupt if that interrupt is enabled. Requests that arrive while a burst is running wait in a small queue.

Top module: `rtsi_top`

## Requirements
- R1: The status word places message error at bit 10 and broadcast received at bit 4. Every other bit equals the matching bit of the configuration register (host address 0). Configuration bits 10 and 4 have no effect on the status word.
- R2: `msg_err` or `cmd_illegal` sets status bit 10, and `bcast_rcvd` sets status bit 4, from the next clock onward. `msg_start` clears both bits. When a set and a clear arrive in the same cycle, the set wins.
- R3: Message error sets pending bit 0 and illegal command sets pending bit 1. `hp_irq` is the OR of each pending bit ANDed with its enable bit (host address 1, bits 0 and 1).
- R4: `hold` rises on the clock after `msg_err`, whatever the enables are. It stays high until the host acknowledges pending bit 0.
- R5: The acknowledge register (host address 2) is write-one-to-clear. Bit 0 clears message error, bit 1 clears illegal command and bit 2 clears the standard level. Writing zeros changes nothing. If an event arrives in the same cycle as the clear of its own bit, the event wins.
- R6: A standard log burst keeps `dma_req` high across three words: write the status word to base, write the descriptor pointer to base+1, read from base+2. The base is at host address 3. A word advances only on the clock where `dma_ack` is high. While idle, `dma_addr` and `dma_wdata` are zero.
- R7: The word read in the third access of a burst is stored as the tail pointer, which is readable at host address 4.
- R8: After the third acknowledge, `std_pulse_n` goes low for exactly one cycle. On the following clock the standard pending bit is set. `std_irq` is that bit ANDed with enable bit 2.
- R9: Requests are logged in arrival order through a queue of QDEPTH entries. A request that arrives while the queue is full is discarded.
- R10: `host_rdata` shows, one clock later, the register selected by `host_addr`. Address 2 returns the pending bits {standard, illegal, message error} in bits 2..0. Unused addresses read zero.
- R11: After reset the status word, enables, pending bits, base, tail and all DMA outputs are zero, and `std_pulse_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| msg_start | input | 1 | New message begins; clears internal status flags |
| msg_err | input | 1 | Message error detected |
| cmd_illegal | input | 1 | Illegal command received |
| bcast_rcvd | input | 1 | Broadcast command received |
| std_req | input | 1 | Standard interrupt request |
| std_isw | input | 16 | Interrupt status word to log |
| std_desc | input | 16 | Descriptor block pointer to log |
| dma_req | output | 1 | DMA request, held for the whole burst |
| dma_we | output | 1 | DMA write (1) or read (0) |
| dma_addr | output | DMA_AW | DMA word address |
| dma_wdata | output | 16 | DMA write data |
| dma_ack | input | 1 | DMA word completed |
| dma_rdata | input | 16 | DMA read data, valid with dma_ack |
| status_word | output | 16 | Terminal status word |
| hold | output | 1 | Terminal held after a message error |
| hp_irq | output | 1 | High-priority interrupt level |
| std_pulse_n | output | 1 | Active-low standard interrupt pulse |
| std_irq | output | 1 | Standard interrupt level |

## Verification
Two things can happen in the same cycle: a host acknowledge, and the very event that the acknowledge clears. This covers a message error arriving on the same clock as a write that clears pending bit 0, and a log burst setting the standard pending bit while the host clears bit 2. The bench provokes the first with a directed write placed on the error cycle. It provokes the second by repeating acknowledge writes during a run of queued bursts with acknowledge wait states. A behavioural model in which the event wins is compared against every output on every clock.

// File: rtl/rtsi_pkg.sv
package rtsi_pkg;
  localparam int WORD_W = 16;
  localparam int HOST_AW = 3;

  localparam logic [HOST_AW-1:0] A_CFG  = 3'd0;
  localparam logic [HOST_AW-1:0] A_EN   = 3'd1;
  localparam logic [HOST_AW-1:0] A_ACK  = 3'd2;
  localparam logic [HOST_AW-1:0] A_BASE = 3'd3;
  localparam logic [HOST_AW-1:0] A_TAIL = 3'd4;

  localparam int BIT_ME = 10;
  localparam int BIT_BC = 4;
  localparam int NHP    = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ISW, S_DSC, S_TAIL, S_SIG
  } log_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] isw;
    logic [WORD_W-1:0] dsc;
  } log_entry_t;
endpackage

// File: rtl/rtsi_status.sv
module rtsi_status
  import rtsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cfg,
  input  logic              msg_start,
  input  logic              msg_err,
  input  logic              cmd_illegal,
  input  logic              bcast_rcvd,
  output logic [WORD_W-1:0] status_word
);
  logic me_q, bc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      me_q <= 1'b0;
      bc_q <= 1'b0;
    end else begin
      if (msg_err || cmd_illegal) me_q <= 1'b1;
      else if (msg_start)         me_q <= 1'b0;
      if (bcast_rcvd)             bc_q <= 1'b1;
      else if (msg_start)         bc_q <= 1'b0;
    end
  end

  always_comb begin
    status_word         = cfg;
    status_word[BIT_ME] = me_q;
    status_word[BIT_BC] = bc_q;
  end
endmodule

// File: rtl/rtsi_hpi.sv
module rtsi_hpi
  import rtsi_pkg::*;
#(
  parameter int NSRC = NHP
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  input  logic            ack_we,
  input  logic [NSRC-1:0] ack_bits,
  output logic [NSRC-1:0] pend,
  output logic            hold,
  output logic            hp_irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic p_q;
    always_ff @(posedge clk) begin
      if (rst)                        p_q <= 1'b0;
      else if (src[i])                p_q <= 1'b1;
      else if (ack_we && ack_bits[i]) p_q <= 1'b0;
    end
    assign pend[i] = p_q;
  end

  assign hold   = pend[0];
  assign hp_irq = |(pend & en);
endmodule

// File: rtl/rtsi_regs.sv
module rtsi_regs
  import rtsi_pkg::*;
#(
  parameter int DMA_AW = 16
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic [2:0]         pend_bits,
  input  logic [WORD_W-1:0]  tail,
  output logic [WORD_W-1:0]  cfg,
  output logic [2:0]         en,
  output logic [DMA_AW-1:0]  base,
  output logic               ack_we,
  output logic [2:0]         ack_bits,
  output logic [WORD_W-1:0]  host_rdata
);
  logic [WORD_W-1:0] rd_d;

  assign ack_we   = host_we && (host_addr == A_ACK);
  assign ack_bits = host_wdata[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      en   <= '0;
      base <= '0;
    end else if (host_we) begin
      case (host_addr)
        A_CFG:   cfg  <= host_wdata;
        A_EN:    en   <= host_wdata[2:0];
        A_BASE:  base <= host_wdata[DMA_AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (host_addr)
      A_CFG:   rd_d = cfg;
      A_EN:    rd_d = {{(WORD_W-3){1'b0}}, en};
      A_ACK:   rd_d = {{(WORD_W-3){1'b0}}, pend_bits};
      A_BASE:  rd_d = WORD_W'(base);
      A_TAIL:  rd_d = tail;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_d;
  end
endmodule

// File: rtl/rtsi_stdlog.sv
module rtsi_stdlog
  import rtsi_pkg::*;
#(
  parameter int DMA_AW = 16,
  parameter int QDEPTH = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              std_req,
  input  logic [WORD_W-1:0] std_isw,
  input  logic [WORD_W-1:0] std_desc,
  input  logic [DMA_AW-1:0] base,
  input  logic              en_lvl,
  input  logic              clr,
  input  logic              dma_ack,
  input  logic [WORD_W-1:0] dma_rdata,
  output logic              dma_req,
  output logic              dma_we,
  output logic [DMA_AW-1:0] dma_addr,
  output logic [WORD_W-1:0] dma_wdata,
  output logic [WORD_W-1:0] tail,
  output logic              std_pulse_n,
  output logic              std_pend,
  output logic              std_irq
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(QDEPTH - 1);

  log_entry_t        mem [QDEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              push, pop;
  log_state_t        state;
  log_entry_t        cur;

  assign push = std_req && (count != CW'(QDEPTH));
  assign pop  = (state == S_IDLE) && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= '{isw: std_isw, dsc: std_desc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur      <= '0;
      tail     <= '0;
      std_pend <= 1'b0;
    end else begin
      if (state == S_SIG) std_pend <= 1'b1;
      else if (clr)       std_pend <= 1'b0;
      case (state)
        S_IDLE: if (pop) begin
          cur   <= mem[rd_ptr];
          state <= S_ISW;
        end
        S_ISW:  if (dma_ack) state <= S_DSC;
        S_DSC:  if (dma_ack) state <= S_TAIL;
        S_TAIL: if (dma_ack) begin
          tail  <= dma_rdata;
          state <= S_SIG;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dma_req   = 1'b0;
    dma_we    = 1'b0;
    dma_addr  = '0;
    dma_wdata = '0;
    case (state)
      S_ISW: begin
        dma_req = 1'b1; dma_we = 1'b1; dma_addr = base; dma_wdata = cur.isw;
      end
      S_DSC: begin
        dma_req = 1'b1; dma_we = 1'b1; dma_addr = base + DMA_AW'(1); dma_wdata = cur.dsc;
      end
      S_TAIL: begin
        dma_req = 1'b1; dma_addr = base + DMA_AW'(2);
      end
      default: ;
    endcase
  end

  assign std_pulse_n = (state != S_SIG);
  assign std_irq     = std_pend && en_lvl;
endmodule

// File: rtl/rtsi_top.sv
module rtsi_top
  import rtsi_pkg::*;
#(
  parameter int DMA_AW = 16,
  parameter int QDEPTH = 4
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic               msg_start,
  input  logic               msg_err,
  input  logic               cmd_illegal,
  input  logic               bcast_rcvd,
  input  logic               std_req,
  input  logic [WORD_W-1:0]  std_isw,
  input  logic [WORD_W-1:0]  std_desc,
  output logic               dma_req,
  output logic               dma_we,
  output logic [DMA_AW-1:0]  dma_addr,
  output logic [WORD_W-1:0]  dma_wdata,
  input  logic               dma_ack,
  input  logic [WORD_W-1:0]  dma_rdata,
  output logic [WORD_W-1:0]  status_word,
  output logic               hold,
  output logic               hp_irq,
  output logic               std_pulse_n,
  output logic               std_irq
);
  logic [WORD_W-1:0] cfg_q, tail_q;
  logic [2:0]        en_q, ack_bits;
  logic [DMA_AW-1:0] base_q;
  logic              ack_we, std_pend;
  logic [NHP-1:0]    hp_pend;

  rtsi_regs #(.DMA_AW(DMA_AW)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .pend_bits({std_pend, hp_pend}), .tail(tail_q),
    .cfg(cfg_q), .en(en_q), .base(base_q), .ack_we(ack_we),
    .ack_bits(ack_bits), .host_rdata(host_rdata)
  );

  rtsi_status u_status (
    .clk(clk), .rst(rst), .cfg(cfg_q), .msg_start(msg_start),
    .msg_err(msg_err), .cmd_illegal(cmd_illegal), .bcast_rcvd(bcast_rcvd),
    .status_word(status_word)
  );

  rtsi_hpi #(.NSRC(NHP)) u_hpi (
    .clk(clk), .rst(rst), .src({cmd_illegal, msg_err}), .en(en_q[NHP-1:0]),
    .ack_we(ack_we), .ack_bits(ack_bits[NHP-1:0]), .pend(hp_pend),
    .hold(hold), .hp_irq(hp_irq)
  );

  rtsi_stdlog #(.DMA_AW(DMA_AW), .QDEPTH(QDEPTH)) u_log (
    .clk(clk), .rst(rst), .std_req(std_req), .std_isw(std_isw),
    .std_desc(std_desc), .base(base_q), .en_lvl(en_q[2]),
    .clr(ack_we && ack_bits[2]), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .tail(tail_q), .std_pulse_n(std_pulse_n),
    .std_pend(std_pend), .std_irq(std_irq)
  );
endmodule

// File: rtl/rtsi_checker.sv
module rtsi_checker #(
  parameter int DMA_AW = 16
)(
  input logic              clk,
  input logic              rst,
  input logic              msg_err,
  input logic              host_we,
  input logic [2:0]        host_addr,
  input logic [15:0]       host_wdata,
  input logic              hold,
  input logic              hp_irq,
  input logic [2:0]        en,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              dma_we,
  input logic [DMA_AW-1:0] dma_addr,
  input logic              std_pulse_n,
  input logic              std_pend,
  input logic [15:0]       status_word
);
  // R2
  me_set_chk: assert property (@(posedge clk) disable iff (rst)
    msg_err |=> status_word[10]);

  // R4
  hold_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(msg_err));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    hold && !(host_we && host_addr == 3'd2 && host_wdata[0]) |=> hold);

  // R3
  hp_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (en[1:0] == 2'b00) |-> !hp_irq);

  // R6
  dma_stall_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_ack |=> dma_req && $stable(dma_addr) && $stable(dma_we));

  // R8
  pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
    !std_pulse_n |=> std_pulse_n);

  // R8
  pend_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !std_pulse_n |=> std_pend);
endmodule

bind rtsi_top rtsi_checker #(.DMA_AW(DMA_AW)) u_chk (
  .clk(clk), .rst(rst), .msg_err(msg_err), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .hold(hold),
  .hp_irq(hp_irq), .en(en_q), .dma_req(dma_req), .dma_ack(dma_ack),
  .dma_we(dma_we), .dma_addr(dma_addr), .std_pulse_n(std_pulse_n),
  .std_pend(std_pend), .status_word(status_word)
);

// File: tb/rtsi_top_tb_top.sv
`timescale 1ns/1ps
module rtsi_top_tb_top;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        msg_start = 1'b0, msg_err = 1'b0, cmd_illegal = 1'b0, bcast_rcvd = 1'b0;
  logic        std_req = 1'b0;
  logic [15:0] std_isw = '0, std_desc = '0;
  logic        dma_req, dma_we;
  logic [15:0] dma_addr, dma_wdata;
  logic        dma_ack = 1'b0;
  logic [15:0] dma_rdata = '0;
  logic [15:0] status_word;
  logic        hold, hp_irq, std_pulse_n, std_irq;

  always #5 clk = ~clk;

  rtsi_top #(.DMA_AW(16), .QDEPTH(QD)) dut_i (.*);

  int tests = 0, fails = 0, pulses = 0, cyc = 0;
  bit done = 0, auto_ack = 1, slow_ack = 0;

  // reference model state
  logic [15:0] m_cfg, m_base, m_tail, m_rd, m_ci, m_cd;
  logic [2:0]  m_en;
  logic [1:0]  m_pend;
  logic        m_stdp, m_me, m_bc;
  int          m_ph;
  logic [15:0] qi[$], qd[$];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cfg;
      3'd1: return {13'b0, m_en};
      3'd2: return {13'b0, m_stdp, m_pend};
      3'd3: return m_base;
      3'd4: return m_tail;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_step();
    logic [15:0] clrv, rdn;
    int old_ph, old_sz;
    if (rst) begin
      m_cfg = 0; m_base = 0; m_tail = 0; m_rd = 0; m_ci = 0; m_cd = 0;
      m_en = 0; m_pend = 0; m_stdp = 0; m_me = 0; m_bc = 0; m_ph = 0;
      qi.delete(); qd.delete();
      return;
    end
    clrv = (host_we && host_addr == 3'd2) ? host_wdata : 16'h0;
    rdn = m_read(host_addr);
    m_pend = (m_pend & ~clrv[1:0]) | {cmd_illegal, msg_err};
    if (msg_err || cmd_illegal) m_me = 1; else if (msg_start) m_me = 0;
    if (bcast_rcvd) m_bc = 1; else if (msg_start) m_bc = 0;
    old_ph = m_ph; old_sz = qi.size();
    m_stdp = (old_ph == 4) ? 1'b1 : (m_stdp & ~clrv[2]);
    case (old_ph)
      0: if (old_sz > 0) begin m_ci = qi.pop_front(); m_cd = qd.pop_front(); m_ph = 1; end
      1, 2: if (dma_ack) m_ph = old_ph + 1;
      3: if (dma_ack) begin m_tail = dma_rdata; m_ph = 4; end
      default: m_ph = 0;
    endcase
    if (std_req && old_sz < QD) begin qi.push_back(std_isw); qd.push_back(std_desc); end
    if (host_we) begin
      case (host_addr)
        3'd0: m_cfg = host_wdata;
        3'd1: m_en = host_wdata[2:0];
        3'd3: m_base = host_wdata;
        default: ;
      endcase
    end
    m_rd = rdn;
  endtask

  task automatic compare();
    logic [15:0] sw, ea, ew;
    bit er, ewe;
    sw = m_cfg; sw[10] = m_me; sw[4] = m_bc;
    er = (m_ph >= 1 && m_ph <= 3);
    ewe = (m_ph == 1 || m_ph == 2);
    ea = er ? m_base + 16'(m_ph - 1) : 16'h0;
    ew = (m_ph == 1) ? m_ci : (m_ph == 2) ? m_cd : 16'h0;
    chk(status_word == sw, "R1/R2 status_word", status_word, sw);
    chk(hold == m_pend[0], "R4 hold", {15'b0, hold}, {15'b0, m_pend[0]});
    chk(hp_irq == |(m_pend & m_en[1:0]), "R3 hp_irq", {15'b0, hp_irq}, {15'b0, |(m_pend & m_en[1:0])});
    chk(std_pulse_n == (m_ph != 4), "R8 std_pulse_n", {15'b0, std_pulse_n}, {15'b0, m_ph != 4});
    chk(std_irq == (m_stdp & m_en[2]), "R8 std_irq", {15'b0, std_irq}, {15'b0, m_stdp & m_en[2]});
    chk(dma_req == er && dma_we == ewe, "R6 dma_req/we", {14'b0, dma_req, dma_we}, {14'b0, er, ewe});
    chk(dma_addr == ea, "R6/R9 dma_addr", dma_addr, ea);
    chk(dma_wdata == ew, "R6/R9 dma_wdata", dma_wdata, ew);
    chk(host_rdata == m_rd, "R10 host_rdata", host_rdata, m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    compare();
    if (!std_pulse_n) pulses++;
    host_we = 0; msg_start = 0; msg_err = 0; cmd_illegal = 0; bcast_rcvd = 0; std_req = 0;
    dma_ack = auto_ack && dma_req && (!slow_ack || cyc[0]);
    dma_rdata = dma_addr ^ 16'hA5A5;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R11 reset state
    chk(status_word == 0 && hold == 0 && hp_irq == 0 && std_irq == 0, "R11 reset outputs", status_word, 16'h0);
    chk(std_pulse_n == 1 && dma_req == 0 && dma_addr == 0, "R11 reset dma/pulse", dma_addr, 16'h0);

    // R1: config bits 10 and 4 are ignored
    wr(3'd0, 16'hFFFF);
    chk(status_word == 16'hFBEF, "R1 masked cfg bits", status_word, 16'hFBEF);
    wr(3'd0, 16'h5A3C);
    for (int a = 0; a < 8; a++) begin host_addr = 3'(a); tick(); end

    // R2: set, clear and collision
    bcast_rcvd = 1; tick();
    chk(status_word[4] == 1, "R2 broadcast set", status_word, 16'h5A3C | 16'h0010);
    cmd_illegal = 1; tick();
    msg_start = 1; tick();
    chk(status_word[10] == 0 && status_word[4] == 0, "R2 msg_start clears", status_word, 16'h5A2C & 16'hFBEF);
    msg_start = 1; msg_err = 1; tick();
    chk(status_word[10] == 1, "R2 set wins over clear", status_word, 16'h5E2C);

    // R4/R5 hold with enables off; zero write ignored
    wr(3'd2, 16'h0002);
    wr(3'd2, 16'h0000);
    chk(hold == 1 && hp_irq == 0, "R4 hold without enable", {15'b0, hold}, 16'h1);
    wr(3'd1, 16'h0003);
    chk(hp_irq == 1, "R3 enabled hp_irq", {15'b0, hp_irq}, 16'h1);
    cmd_illegal = 1; tick();
    wr(3'd2, 16'h0002);
    chk(hold == 1, "R5 ack of bit1 keeps hold", {15'b0, hold}, 16'h1);
    host_we = 1; host_addr = 3'd2; host_wdata = 16'h0001; msg_err = 1; tick();
    chk(hold == 1, "R5 event beats clear", {15'b0, hold}, 16'h1);
    wr(3'd2, 16'h0001);
    chk(hold == 0 && hp_irq == 0, "R5 ack releases hold", {15'b0, hold}, 16'h0);

    // R6/R7/R8 single log burst
    wr(3'd3, 16'h0100);
    wr(3'd1, 16'h0004);
    pulses = 0;
    std_req = 1; std_isw = 16'h1111; std_desc = 16'h2222; tick();
    repeat (10) tick();
    chk(pulses == 1, "R8 one pulse per burst", 16'(pulses), 16'h1);
    chk(std_irq == 1, "R8 level raised", {15'b0, std_irq}, 16'h1);
    host_addr = 3'd4; tick(); tick();
    chk(host_rdata == (16'h0102 ^ 16'hA5A5), "R7 tail readable", host_rdata, 16'h0102 ^ 16'hA5A5);
    wr(3'd2, 16'h0004);
    chk(std_irq == 0, "R5 std level cleared", {15'b0, std_irq}, 16'h0);

    // R9 queue with overflow, wait states and repeated clears
    slow_ack = 1; auto_ack = 0; pulses = 0;
    for (int i = 0; i < 7; i++) begin
      std_req = 1; std_isw = 16'(16'h3000 + i); std_desc = 16'(16'h4000 + i); tick();
    end
    auto_ack = 1;
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 0) begin host_we = 1; host_addr = 3'd2; host_wdata = 16'h0004; end
      tick();
    end
    chk(pulses == 1 + QD, "R9 overflow drops extra requests", 16'(pulses), 16'(1 + QD));

    // R8 level masked when disabled
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0004);
    slow_ack = 0;
    std_req = 1; std_isw = 16'h5555; std_desc = 16'h6666; tick();
    repeat (8) tick();
    chk(std_irq == 0, "R8 level masked", {15'b0, std_irq}, 16'h0);
    host_addr = 3'd2; tick(); tick();
    chk(host_rdata[2] == 1, "R10 pending readable", host_rdata, 16'h0004);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule